// File: doc/BRIEF.md
# Strobe-driven configuration byte port

This block lets an external processor push configuration bytes into a device over a byte-wide bus. The processor drives two chip-select lines, a write strobe, a read strobe and an 8-bit data bus, with no timing tie to the internal clock. The port resynchronises all of these lines and captures one byte per write strobe into a single-entry holding buffer. It then offers that byte to an internal consumer, for example a serializer, over a valid/ready handshake.

The processor paces itself by issuing status reads. During a read the port drives the bus with a ready/busy flag on the top bit and ones on every other bit. Outside a status read the bus driver is disabled. A byte written while the buffer still holds an unaccepted byte is discarded, and a sticky flag records the loss. If both strobes are low at once, the write is performed and the read is ignored.

Top module: `cfg_strobe_port`

## Requirements
- R1: The port is selected only while `cs_lo_n` is 0 and `cs_hi` is 1. Without selection, strobes capture nothing and never enable the bus driver.
- R2: While the port is selected, a falling edge of `wr_n` captures `bus_in`. `byte_valid` becomes 1 and `byte_data` holds the captured byte from the third rising clock edge after the edge is sampled.
- R3: While the port is selected with `rd_n` at 0 and `wr_n` at 1, `bus_oe` is 1. `bus_out[7]` is then 1 when the buffer is empty (ready) and 0 when it holds a byte (busy). This appears from the second rising edge after sampling.
- R4: During a status read, `bus_out[6:0]` equals 7'h7F.
- R5: When `wr_n` and `rd_n` are both 0 while the port is selected, the port performs the write and leaves `bus_oe` at 0.
- R6: When no status read is active, `bus_oe` is 0 and `bus_out` is 8'h00.
- R7: Busy (`byte_valid`) is set by a capture. It stays set, with `byte_data` unchanged, until a rising edge where `byte_valid` and `byte_ready` are both 1, and it clears after that edge.
- R8: A write edge that arrives while busy is dropped and sets `overrun`. `overrun` stays 1 until reset.
- R9: Holding `wr_n` low captures exactly once. No further capture happens until a new falling edge, even after the held byte is accepted.
- R10: While `rst_n` is low at a clock edge, the port clears `byte_valid`, `overrun` and `bus_oe` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_lo_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| bus_in | input | 8 | Data bus as seen by the port |
| bus_out | output | 8 | Value driven onto the bus during a status read |
| bus_oe | output | 1 | Bus driver enable |
| byte_valid | output | 1 | Holding buffer occupied (busy) |
| byte_data | output | 8 | Buffered byte |
| byte_ready | input | 1 | Consumer accepts the buffered byte |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The hardest situation to reach from the ports is a write edge that is sampled in the same clock cycle in which the consumer accepts the held byte. That write must be dropped and flagged, not taken into the buffer that is just being emptied. The bench holds `byte_ready` low to keep the buffer full, launches a second write, and raises `byte_ready` at chosen offsets around the synchronizer delay. A cycle-accurate behavioural model of the delay line then shows whether each write edge falls before, on or after the acceptance edge. The bench also holds `wr_n` low across an acceptance to test the single-capture rule, and it drives both strobes together while the buffer is busy and while it is empty.

// File: rtl/cfgp_pkg.sv
// Package for the configuration byte port.
// It holds the state type of the holding buffer and the reset level of the control lines.
// Assumes the control lines are bundled in the order {cs_lo_n, cs_hi, wr_n, rd_n}.
package cfgp_pkg;
    typedef enum logic {
        HB_EMPTY = 1'b0,
        HB_FULL  = 1'b1
    } hold_state_t;

    localparam int CTRL_W = 4;
    // Idle levels: deselected, with both strobes released
    localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b1011;
endpackage

// File: rtl/cfgp_sync.sv
// Multi-flop synchronizer for a bundle of asynchronous lines.
// Each bit passes through STAGES flops, which reset to RESET_VAL.
// Assumes that a multi-bit bundle is held stable around each strobe edge, so skew between bits does not matter.
module cfgp_sync #(
    parameter int                WIDTH     = 1,
    parameter int                STAGES    = 2,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop: samples the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RESET_VAL;
                    else        stage_q[g] <= async_in;
                end
            end else begin : g_next
                // Later flops: let metastability settle
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RESET_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cfgp_strobe_dec.sv
// Decodes the synchronized chip selects and strobes.
// It produces a one-cycle write pulse on each new selected write and a level that marks an active status read.
// A write that is active blocks the read, so write wins a strobe conflict.
// Assumes all inputs are already synchronized to clk.
module cfgp_strobe_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_lo_n_s,
    input  logic cs_hi_s,
    input  logic wr_n_s,
    input  logic rd_n_s,
    output logic wr_fire,
    output logic rd_active
);
    logic selected;
    logic wr_act;
    logic wr_act_q;

    // Selection decode and strobe qualification
    always_comb begin
        selected  = !cs_lo_n_s && cs_hi_s;
        wr_act    = selected && !wr_n_s;
        rd_active = selected && !rd_n_s && wr_n_s;
    end

    // Remember the previous write level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) wr_act_q <= 1'b0;
        else        wr_act_q <= wr_act;
    end

    assign wr_fire = wr_act && !wr_act_q;
endmodule

// File: rtl/cfgp_hold_buf.sv
// Single-entry holding buffer with a valid/ready output side.
// A write pulse fills an empty buffer. A write pulse that meets a full buffer is dropped and sets the sticky overrun flag, even when the buffer drains in the same cycle.
// Assumes wr_fire is a one-cycle pulse.
module cfgp_hold_buf
    import cfgp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [DATA_W-1:0] wr_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              overrun
);
    hold_state_t       state_q;
    logic [DATA_W-1:0] data_q;
    logic              ovr_q;

    // Fill, drain and overrun tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HB_EMPTY;
            data_q  <= '0;
            ovr_q   <= 1'b0;
        end else begin
            case (state_q)
                HB_EMPTY: begin
                    if (wr_fire) begin
                        data_q  <= wr_data;
                        state_q <= HB_FULL;
                    end
                end
                HB_FULL: begin
                    if (out_ready) state_q <= HB_EMPTY;
                    if (wr_fire)   ovr_q   <= 1'b1;
                end
                default: state_q <= HB_EMPTY;
            endcase
        end
    end

    assign out_valid = (state_q == HB_FULL);
    assign out_data  = data_q;
    assign overrun   = ovr_q;
endmodule

// File: rtl/cfg_strobe_port.sv
// Top level of the strobe-driven configuration byte port.
// It synchronizes the asynchronous bus lines, decodes strobes, buffers one byte and drives the status word during reads.
// Assumes that bus_in is stable while wr_n is low.
module cfg_strobe_port
    import cfgp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lo_n,
    input  logic              cs_hi,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    input  logic              byte_ready,
    output logic              overrun
);
    localparam int LOW_W = DATA_W - 1;

    logic [CTRL_W-1:0] ctrl_s;
    logic [DATA_W-1:0] data_s;
    logic              wr_fire;
    logic              rd_active;

    cfgp_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RESET_VAL(CTRL_IDLE)) u_ctrl_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_lo_n, cs_hi, wr_n, rd_n}),
        .sync_out (ctrl_s)
    );

    cfgp_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_data_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_in),
        .sync_out (data_s)
    );

    cfgp_strobe_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lo_n_s (ctrl_s[3]),
        .cs_hi_s   (ctrl_s[2]),
        .wr_n_s    (ctrl_s[1]),
        .rd_n_s    (ctrl_s[0]),
        .wr_fire   (wr_fire),
        .rd_active (rd_active)
    );

    cfgp_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fire   (wr_fire),
        .wr_data   (data_s),
        .out_valid (byte_valid),
        .out_data  (byte_data),
        .out_ready (byte_ready),
        .overrun   (overrun)
    );

    // Status word: ready on the top bit, ones below; quiet when no read is active
    always_comb begin
        bus_oe  = rd_active;
        bus_out = '0;
        if (rd_active) bus_out = {!byte_valid, {LOW_W{1'b1}}};
    end
endmodule

// File: rtl/cfg_strobe_port_checker.sv
// Port-level checker for cfg_strobe_port, attached with bind.
// Assumes the default two-stage synchronizer, so pin effects appear two edges later.
module cfg_strobe_port_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_lo_n,
    input logic       cs_hi,
    input logic       wr_n,
    input logic [7:0] bus_out,
    input logic       bus_oe,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       byte_ready,
    input logic       overrun
);
    p_oe_needs_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> ($past(!cs_lo_n && cs_hi, 2)));

    p_ready_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_out[7] == !byte_valid));

    p_status_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_out[6:0] == 7'h7F));

    p_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(wr_n, 2));

    p_quiet_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == 8'h00));

    p_hold_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind cfg_strobe_port cfg_strobe_port_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_lo_n    (cs_lo_n),
    .cs_hi      (cs_hi),
    .wr_n       (wr_n),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_ready (byte_ready),
    .overrun    (overrun)
);

// File: tb/cfg_strobe_port_bench.sv
module cfg_strobe_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_lo_n = 1'b1, cs_hi = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic       byte_ready = 1'b0;
    logic [7:0] bus_out, byte_data;
    logic       bus_oe, byte_valid, overrun;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    cfg_strobe_port u_cfg_strobe_port (
        .clk(clk), .rst_n(rst_n), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
        .wr_n(wr_n), .rd_n(rd_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: pin snapshots taken at each edge, newest first
    typedef struct packed { logic csn; logic cs; logic wn; logic rn; logic [7:0] d; } snap_t;
    localparam snap_t IDLE_SNAP = '{csn:1'b1, cs:1'b0, wn:1'b1, rn:1'b1, d:8'h00};
    snap_t hist [$];
    bit        m_busy = 0, m_ovr = 0;
    logic [7:0] m_data = 8'h00;
    int        m_captures = 0;

    function automatic bit wr_on(snap_t s);
        return !s.csn && s.cs && !s.wn;
    endfunction
    function automatic bit rd_on(snap_t s);
        return !s.csn && s.cs && !s.rn && s.wn;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{IDLE_SNAP, IDLE_SNAP, IDLE_SNAP, IDLE_SNAP};
            m_busy = 0; m_ovr = 0; m_data = 8'h00;
        end else begin
            bit fire, was_busy;
            hist.push_front('{csn:cs_lo_n, cs:cs_hi, wn:wr_n, rn:rd_n, d:bus_in});
            void'(hist.pop_back());
            fire = wr_on(hist[2]) && !wr_on(hist[3]);
            was_busy = m_busy;
            if (was_busy && byte_ready) m_busy = 0;
            if (fire) begin
                if (was_busy) m_ovr = 1;
                else begin m_busy = 1; m_data = hist[2].d; m_captures++; end
            end
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare outputs against the model on every clock, away from the edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            bit exp_oe;
            exp_oe = rd_on(hist[1]);
            check("R3/R6 bus_oe", {7'b0, bus_oe}, {7'b0, exp_oe});
            check("R4/R6 bus_out", bus_out, exp_oe ? {!m_busy, 7'h7F} : 8'h00);
            check("R7 byte_valid", {7'b0, byte_valid}, {7'b0, m_busy});
            if (m_busy) check("R2 byte_data", byte_data, m_data);
            check("R8 overrun", {7'b0, overrun}, {7'b0, m_ovr});
        end
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic pins(logic a, logic b, logic w, logic r, logic [7:0] d);
        @(negedge clk);
        cs_lo_n = a; cs_hi = b; wr_n = w; rd_n = r; bus_in = d;
    endtask
    task automatic write_byte(logic [7:0] d);
        pins(0, 1, 1, 1, d); pins(0, 1, 0, 1, d); idle(3);
        pins(0, 1, 1, 1, d); pins(1, 0, 1, 1, d); idle(3);
    endtask
    task automatic status_read(output logic [7:0] v);
        pins(0, 1, 1, 0, 8'h00); idle(3);
        v = bus_out;
        pins(1, 0, 1, 1, 8'h00); idle(3);
    endtask

    initial begin
        logic [7:0] st;
        int caps;
        idle(3);
        // R10: reset state
        check("R10 reset byte_valid", {7'b0, byte_valid}, 8'h00);
        check("R10 reset overrun", {7'b0, overrun}, 8'h00);
        check("R10 reset bus_oe", {7'b0, bus_oe}, 8'h00);
        pins(1, 0, 1, 1, 8'h00); rst_n = 1'b1; idle(4);

        // R3: ready when empty
        status_read(st);
        check("R3 ready status", st, 8'hFF);

        // R2, R7: capture and hold while consumer stalls
        write_byte(8'hA5);
        check("R2 captured byte", byte_data, 8'hA5);
        check("R7 busy held", {7'b0, byte_valid}, 8'h01);
        status_read(st);
        check("R3 busy status", st, 8'h7F);

        // R8: write while busy is dropped
        write_byte(8'h3C);
        check("R8 overrun set", {7'b0, overrun}, 8'h01);
        check("R8 byte kept", byte_data, 8'hA5);

        // R7: accept clears busy
        pins(1, 0, 1, 1, 8'h00); byte_ready = 1'b1; idle(1); byte_ready = 1'b0; idle(2);
        check("R7 busy cleared", {7'b0, byte_valid}, 8'h00);

        // R1: deselected strobes ignored (each wrong select pattern)
        caps = m_captures;
        pins(1, 1, 0, 1, 8'h11); idle(3); pins(1, 1, 1, 0, 8'h11); idle(3);
        pins(0, 0, 0, 1, 8'h22); idle(3); pins(0, 0, 1, 0, 8'h22); idle(3);
        pins(1, 0, 0, 0, 8'h33); idle(3);
        pins(1, 0, 1, 1, 8'h00); idle(3);
        check("R1 no capture when deselected", {7'b0, byte_valid}, 8'h00);
        check("R1 model agrees", m_captures[7:0], caps[7:0]);

        // R5: conflict, write wins
        pins(0, 1, 1, 1, 8'h5A); pins(0, 1, 0, 0, 8'h5A); idle(3);
        check("R5 no status drive", {7'b0, bus_oe}, 8'h00);
        check("R5 write taken", byte_data, 8'h5A);
        pins(1, 0, 1, 1, 8'h00); idle(3);
        // Conflict while busy: still no drive, overrun already sticky
        pins(0, 1, 0, 0, 8'h66); idle(3);
        check("R5 busy conflict no drive", {7'b0, bus_oe}, 8'h00);
        pins(1, 0, 1, 1, 8'h00); byte_ready = 1'b1; idle(1); byte_ready = 1'b0; idle(3);

        // R9: hold write low across acceptance -> one capture only
        pins(0, 1, 0, 1, 8'hC3); idle(4);
        byte_ready = 1'b1; idle(1); byte_ready = 1'b0; idle(6);
        check("R9 no second capture", {7'b0, byte_valid}, 8'h00);
        pins(1, 0, 1, 1, 8'h00); idle(3);

        // R8 corner: write edge reaches the buffer on the accept edge (dropped)
        write_byte(8'h81);
        for (int off = 0; off < 5; off++) begin
            pins(0, 1, 0, 1, 8'h90 + off[7:0]);
            idle(off);
            byte_ready = 1'b1; idle(1); byte_ready = 1'b0;
            pins(1, 0, 1, 1, 8'h00); idle(4);
            if (!byte_valid) write_byte(8'h81);
        end
        check("R8 overrun still sticky", {7'b0, overrun}, 8'h01);

        // R10: reset clears overrun
        rst_n = 1'b0; idle(2);
        rst_n = 1'b1; idle(1);
        check("R10 overrun cleared by reset", {7'b0, overrun}, 8'h00);
        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule